// File: doc/BRIEF.md
# Interrupt Distributor Register File

This block is the memory-mapped register file for the global (shared-interrupt) half of an interrupt distributor. A 32-bit register bus reads and writes it: an address, a write strobe with write data, and a read strobe whose data comes back one cycle later. For every shared interrupt it holds an enable bit, a pending bit, an 8-bit priority and a 2-bit trigger configuration. It also returns fixed identification and capability words. Two vectors leave the block, each with one bit per interrupt. One is the current enables. The other is the deliverable pending set: pending, enabled, and the global group-1 enable on.

Interrupt IDs 0 to 31 belong to the per-core frames. Every bank here returns zero for them and ignores writes to them. The architectural bits that this block hard-wires are fixed in the same way: affinity routing on, a single security state, and group 1 only. Where a register is reserved or a feature is absent, the register reads as zero and drops writes. The interrupt count `NUM_IRQ` is a parameter. It must be a multiple of 32 in the range 64 to 1024.

Top module: `dist_regfile`

## Requirements
- R1: Control word (0x000): bit 1 is the group-1 enable. It resets to 0 and holds the value last written. Bit 4 (routing enable) and bit 6 (single security) always read 1. Every other bit reads 0, and writes to them are ignored.
- R2: A write to 0x000 with bit 0 set drives `grp0_req_o` high for exactly the one cycle after the write. Bit 0 stores nothing and reads 0. Bit 1 of the same write still takes effect.
- R3: The type word (0x004) reads ((min(NUM_IRQ,1024)/32)-1) in bits [4:0] and 9 in bits [23:19]. All other bits read 0, which gives 0x00480002 for 96 interrupts. Writes are ignored.
- R4: The implementation word (0x008) reads the product code in [31:24] and the implementer code in [11:0], which by default is 0x4B00043B. The identification window 0xFFD0–0xFFFF reads 0x3B at 0xFFE8 and 0 everywhere else. Both are read-only.
- R5: The group window 0x080–0x0FF reads 0xFFFFFFFF and ignores writes.
- R6: The enable state has two views. The set view (0x100 + 4·k) ORs the written ones into word k. The clear view (0x180 + 4·k) clears the written ones in word k. Both views read the current enable bits of word k. Bit j of word k is interrupt 32·k+j.
- R7: The pending state works the same way, with its set view at 0x200 + 4·k and its clear view at 0x280 + 4·k.
- R8: In all four views, word 0 (interrupts 0–31) and every word at or above NUM_IRQ/32 read 0 and ignore writes.
- R9: The priority word at 0x400 + 4·k holds the bytes for interrupts 4k..4k+3. Byte 0 is the lowest ID. It is read/write. Words 0–7 and words at or above NUM_IRQ/4 read 0 and ignore writes.
- R10: The configuration word at 0xC00 + 4·k holds 2 bits per interrupt for interrupts 16k..16k+15. It is read/write. Words 0–1 and words at or above NUM_IRQ/16 read 0 and ignore writes.
- R11: Every other address reads 0 and ignores writes. This covers the active, target, status, message, group-modifier, access-control and software-interrupt windows.
- R12: `irq_pend_o[i]` is 1 exactly when interrupt i is pending, enabled and the group-1 enable is set. `irq_en_o` mirrors the enable state.
- R13: `bus_rdata_o` carries the addressed word in the cycle after `bus_rd_i` is high, and carries 0 after any cycle without a read. After reset, all stored state is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr_i | input | 16 | Byte address; bits [1:0] are ignored |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| grp0_req_o | output | 1 | One-cycle flag: unsupported group-0 enable requested |
| irq_en_o | output | NUM_IRQ | Per-interrupt enable state |
| irq_pend_o | output | NUM_IRQ | Per-interrupt deliverable pending |

## Verification
Two functions can fall in the same cycle: a single control write can raise the unsupported group-0 flag and also change the group-1 enable. The bench writes 0x3 to exercise this. It then checks that the flag is high for one cycle only, and that the read-back and the pending vector show group 1 switched on. A second collision arises when the gate closes under live pending interrupts. Pending and enable bits are set first, and then the control word is written with bit 1 clear. The bench expects `irq_pend_o` to go to zero while the pending and enable read-backs keep their bits.

// File: rtl/dist_regfile_pkg.sv
// Package: shared constants, region type and address decode for the
// distributor register file. Assumes word-aligned 16-bit byte addresses.
package dist_regfile_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    // Control word bit positions
    localparam int CTL_G0    = 0;
    localparam int CTL_G1    = 1;
    localparam int CTL_ROUTE = 4;
    localparam int CTL_ONESEC = 6;

    localparam logic [ADDR_W-1:0] ID2_ADDR = 16'hFFE8;
    localparam logic [DATA_W-1:0] ID2_VAL  = 32'h0000_003B;

    typedef enum logic [3:0] {
        RG_NONE, RG_CTRL, RG_TYPE, RG_IIDR, RG_GROUP,
        RG_SETEN, RG_CLREN, RG_SETPD, RG_CLRPD,
        RG_PRIO, RG_CFG, RG_IDWIN
    } region_e;

    // Map a word address to the register region it belongs to.
    function automatic region_e decode_region(input logic [ADDR_W-3:0] wa);
        logic [ADDR_W-1:0] a;
        a = {wa, 2'b00};
        if (a == 16'h0000)                        return RG_CTRL;
        else if (a == 16'h0004)                   return RG_TYPE;
        else if (a == 16'h0008)                   return RG_IIDR;
        else if (a >= 16'h0080 && a < 16'h0100)   return RG_GROUP;
        else if (a >= 16'h0100 && a < 16'h0180)   return RG_SETEN;
        else if (a >= 16'h0180 && a < 16'h0200)   return RG_CLREN;
        else if (a >= 16'h0200 && a < 16'h0280)   return RG_SETPD;
        else if (a >= 16'h0280 && a < 16'h0300)   return RG_CLRPD;
        else if (a >= 16'h0400 && a < 16'h0800)   return RG_PRIO;
        else if (a >= 16'h0C00 && a < 16'h0D00)   return RG_CFG;
        else if (a >= 16'hFFD0)                   return RG_IDWIN;
        else                                      return RG_NONE;
    endfunction

endpackage

// File: rtl/dist_ctrl.sv
// Control word: stores the group-1 enable and flags group-0 enable requests.
// Assumes wr_i is already qualified by the control-word address decode.
module dist_ctrl
    import dist_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [1:0]        wbits_i,
    output logic              grp1_en_o,
    output logic              grp0_req_o,
    output logic [DATA_W-1:0] ctrl_word_o
);

    // Register the group-1 enable and the one-cycle group-0 flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp1_en_o  <= 1'b0;
            grp0_req_o <= 1'b0;
        end else begin
            grp0_req_o <= wr_i & wbits_i[CTL_G0];
            if (wr_i) grp1_en_o <= wbits_i[CTL_G1];
        end
    end

    // Assemble the read view with the hard-wired bits set.
    always_comb begin
        ctrl_word_o             = '0;
        ctrl_word_o[CTL_G1]     = grp1_en_o;
        ctrl_word_o[CTL_ROUTE]  = 1'b1;
        ctrl_word_o[CTL_ONESEC] = 1'b1;
    end

    assert_grp0_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        grp0_req_o |-> $past(wr_i && wbits_i[CTL_G0]));

    assert_g1_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(grp1_en_o));

endmodule

// File: rtl/dist_bitbank.sv
// One bit per interrupt, with set and clear write views over shared state.
// Word 0 (private IDs) and words past the interrupt count are never written.
module dist_bitbank
    import dist_regfile_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int IDX_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we_i,
    input  logic              clr_we_i,
    input  logic [IDX_W-1:0]  word_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [NUM_IRQ-1:0] state_o,
    output logic [DATA_W-1:0] rword_o
);

    localparam int NWORD = NUM_IRQ / 32;

    // Apply set or clear writes to shared words only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= '0;
        end else begin
            for (int w = 1; w < NWORD; w++) begin
                if (word_i == IDX_W'(w)) begin
                    if (set_we_i)
                        state_o[w*32 +: 32] <= state_o[w*32 +: 32] | wdata_i;
                    else if (clr_we_i)
                        state_o[w*32 +: 32] <= state_o[w*32 +: 32] & ~wdata_i;
                end
            end
        end
    end

    // Select the addressed word; private and missing words read zero.
    always_comb begin
        rword_o = '0;
        for (int w = 1; w < NWORD; w++)
            if (word_i == IDX_W'(w)) rword_o = state_o[w*32 +: 32];
    end

    assert_setclr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_we_i && clr_we_i));

    assert_word0_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we_i || clr_we_i) && word_i == '0 |=> $stable(state_o));

endmodule

// File: rtl/dist_prio_bank.sv
// Byte-per-interrupt priority storage, four interrupts per word.
// Assumes NUM_IRQ/4 fits the index width; first eight words are read-as-zero.
module dist_prio_bank
    import dist_regfile_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int IDX_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  word_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rword_o
);

    localparam int NWORD  = NUM_IRQ / 4;
    localparam int FIRSTW = 32 / 4;

    logic [7:0] prio_q [NUM_IRQ];

    // Store written bytes for shared interrupts only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IRQ; i++) prio_q[i] <= '0;
        end else if (we_i) begin
            for (int w = FIRSTW; w < NWORD; w++) begin
                if (word_i == IDX_W'(w)) begin
                    for (int b = 0; b < 4; b++)
                        prio_q[4*w + b] <= wdata_i[8*b +: 8];
                end
            end
        end
    end

    // Gather the four bytes of the addressed word.
    always_comb begin
        rword_o = '0;
        for (int w = FIRSTW; w < NWORD; w++)
            if (word_i == IDX_W'(w))
                rword_o = {prio_q[4*w+3], prio_q[4*w+2], prio_q[4*w+1], prio_q[4*w]};
    end

    assert_low_prio_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        word_i < IDX_W'(FIRSTW) |-> rword_o == '0);

endmodule

// File: rtl/dist_cfg_bank.sv
// Two-bit trigger configuration per interrupt, sixteen per word.
// Words 0 and 1 belong to private IDs and are read-as-zero.
module dist_cfg_bank
    import dist_regfile_pkg::*;
#(
    parameter int NUM_IRQ = 96,
    parameter int IDX_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  word_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rword_o
);

    localparam int NWORD  = NUM_IRQ / 16;
    localparam int FIRSTW = 32 / 16;

    logic [DATA_W-1:0] cfg_q [NWORD];

    // Store whole configuration words for shared interrupts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NWORD; w++) cfg_q[w] <= '0;
        end else if (we_i) begin
            for (int w = FIRSTW; w < NWORD; w++)
                if (word_i == IDX_W'(w)) cfg_q[w] <= wdata_i;
        end
    end

    // Select the addressed configuration word.
    always_comb begin
        rword_o = '0;
        for (int w = FIRSTW; w < NWORD; w++)
            if (word_i == IDX_W'(w)) rword_o = cfg_q[w];
    end

    assert_low_cfg_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        word_i < IDX_W'(FIRSTW) |-> rword_o == '0);

endmodule

// File: rtl/dist_regfile.sv
// Top of the distributor register file: decodes bus accesses into the
// control, bit, priority and configuration banks, returns a registered
// read word and gates the pending vector. Assumes one access per cycle,
// NUM_IRQ a multiple of 32 between 64 and 1024.
module dist_regfile
    import dist_regfile_pkg::*;
#(
    parameter int          NUM_IRQ      = 96,
    parameter logic [7:0]  PRODUCT_CODE = 8'h4B,
    parameter logic [11:0] IMPL_CODE    = 12'h43B
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        bus_addr_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic               grp0_req_o,
    output logic [NUM_IRQ-1:0] irq_en_o,
    output logic [NUM_IRQ-1:0] irq_pend_o
);

    localparam int CAP_IRQ = (NUM_IRQ > 1024) ? 1024 : NUM_IRQ;
    localparam logic [DATA_W-1:0] TYPE_WORD =
        DATA_W'((CAP_IRQ / 32) - 1) | (DATA_W'(9) << 19);
    localparam logic [DATA_W-1:0] IIDR_WORD = {PRODUCT_CODE, 12'h000, IMPL_CODE};

    region_e           region;
    logic              grp1_en;
    logic [DATA_W-1:0] ctrl_word, en_rword, pd_rword, prio_rword, cfg_rword;
    logic [DATA_W-1:0] rd_mux;
    logic [NUM_IRQ-1:0] pend_state;
    logic              unused_addr_bits;

    assign unused_addr_bits = ^bus_addr_i[1:0];

    // Decode the addressed region from the word address.
    always_comb region = decode_region(bus_addr_i[ADDR_W-1:2]);

    dist_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr_i && region == RG_CTRL),
        .wbits_i    (bus_wdata_i[1:0]),
        .grp1_en_o  (grp1_en),
        .grp0_req_o (grp0_req_o),
        .ctrl_word_o(ctrl_word)
    );

    dist_bitbank #(.NUM_IRQ(NUM_IRQ), .IDX_W(5)) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we_i (bus_wr_i && region == RG_SETEN),
        .clr_we_i (bus_wr_i && region == RG_CLREN),
        .word_i   (bus_addr_i[6:2]),
        .wdata_i  (bus_wdata_i),
        .state_o  (irq_en_o),
        .rword_o  (en_rword)
    );

    dist_bitbank #(.NUM_IRQ(NUM_IRQ), .IDX_W(5)) u_pending (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we_i (bus_wr_i && region == RG_SETPD),
        .clr_we_i (bus_wr_i && region == RG_CLRPD),
        .word_i   (bus_addr_i[6:2]),
        .wdata_i  (bus_wdata_i),
        .state_o  (pend_state),
        .rword_o  (pd_rword)
    );

    dist_prio_bank #(.NUM_IRQ(NUM_IRQ), .IDX_W(8)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_wr_i && region == RG_PRIO),
        .word_i  (bus_addr_i[9:2]),
        .wdata_i (bus_wdata_i),
        .rword_o (prio_rword)
    );

    dist_cfg_bank #(.NUM_IRQ(NUM_IRQ), .IDX_W(6)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_wr_i && region == RG_CFG),
        .word_i  (bus_addr_i[7:2]),
        .wdata_i (bus_wdata_i),
        .rword_o (cfg_rword)
    );

    // Gate pending by enable and the global group-1 enable.
    always_comb irq_pend_o = pend_state & irq_en_o & {NUM_IRQ{grp1_en}};

    // Select the read word for the addressed region.
    always_comb begin
        unique case (region)
            RG_CTRL:            rd_mux = ctrl_word;
            RG_TYPE:            rd_mux = TYPE_WORD;
            RG_IIDR:            rd_mux = IIDR_WORD;
            RG_GROUP:           rd_mux = '1;
            RG_SETEN, RG_CLREN: rd_mux = en_rword;
            RG_SETPD, RG_CLRPD: rd_mux = pd_rword;
            RG_PRIO:            rd_mux = prio_rword;
            RG_CFG:             rd_mux = cfg_rword;
            RG_IDWIN:           rd_mux = ({bus_addr_i[15:2], 2'b00} == ID2_ADDR) ? ID2_VAL : '0;
            default:            rd_mux = '0;
        endcase
    end

    // Register the read word; idle cycles return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata_o <= '0;
        else        bus_rdata_o <= bus_rd_i ? rd_mux : '0;
    end

    assert_ctrl_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_i && region == RG_CTRL |=> bus_rdata_o[CTL_ROUTE] && bus_rdata_o[CTL_ONESEC]);

    assert_gate_closed_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr_i && region == RG_CTRL && !bus_wdata_i[CTL_G1] |=> irq_pend_o == '0);

    assert_rd_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_i |=> bus_rdata_o == '0);

    assert_group_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_i && region == RG_GROUP |=> bus_rdata_o == '1);

endmodule

// File: tb/dist_regfile_bench.sv
module dist_regfile_bench;

    localparam int NI = 96;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          grp0_req;
    logic [NI-1:0] irq_en, irq_pend;

    int n_chk = 0;
    int n_fail = 0;
    logic rd_d = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    dist_regfile #(.NUM_IRQ(NI)) u_dist_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr_i (bus_addr),
        .bus_wr_i   (bus_wr),
        .bus_rd_i   (bus_rd),
        .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata),
        .grp0_req_o (grp0_req),
        .irq_en_o   (irq_en),
        .irq_pend_o (irq_pend)
    );

    always @(posedge clk) rd_d <= bus_rd;

    // Monitor: pop an expected read word and compare.
    always @(negedge clk) begin
        if (rd_d) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R13 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s read actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] e, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input logic [NI-1:0] act, input logic [NI-1:0] e, input string tag);
        n_chk++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, e);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL R13 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state (R13, R1)
        chk(irq_pend, '0, "R13 reset pending");
        chk(irq_en, '0, "R13 reset enable");
        chk({95'b0, grp0_req}, '0, "R2 reset flag");
        rd(16'h0000, 32'h0000_0050, "R1 reset control");
        // Fixed words (R3, R4, R5)
        wr(16'h0004, 32'hFFFF_FFFF);
        rd(16'h0004, 32'h0048_0002, "R3 type word");
        rd(16'h0008, 32'h4B00_043B, "R4 implementation word");
        rd(16'hFFE8, 32'h0000_003B, "R4 id2");
        rd(16'hFFE0, 32'h0000_0000, "R4 other id");
        wr(16'h0084, 32'h0);
        rd(16'h0084, 32'hFFFF_FFFF, "R5 group ones");
        // Group-0 and group-1 in one write (R2, R1)
        wr(16'h0000, 32'h0000_0003);
        chk({95'b0, grp0_req}, {95'b0, 1'b1}, "R2 flag raised");
        @(negedge clk);
        chk({95'b0, grp0_req}, '0, "R2 flag one cycle");
        rd(16'h0000, 32'h0000_0052, "R1 group-1 stored");
        // Enable bank (R6, R8)
        wr(16'h0104, 32'h0000_00F0);
        rd(16'h0104, 32'h0000_00F0, "R6 set enable");
        wr(16'h0184, 32'h0000_0030);
        rd(16'h0184, 32'h0000_00C0, "R6 clear enable");
        wr(16'h0100, 32'hFFFF_FFFF);
        rd(16'h0100, 32'h0, "R8 private enable word");
        wr(16'h010C, 32'hFFFF_FFFF);
        rd(16'h010C, 32'h0, "R8 word past count");
        wr(16'h0108, 32'h0000_0001);
        chk(irq_en, 96'h0000_0001_0000_00C0_0000_0000, "R12 enable vector");
        // Pending bank and gating (R7, R12)
        wr(16'h0204, 32'h0000_00C3);
        wr(16'h0208, 32'h0000_0001);
        wr(16'h0200, 32'hFFFF_FFFF);
        rd(16'h0204, 32'h0000_00C3, "R7 set pending");
        rd(16'h0200, 32'h0, "R8 private pending word");
        chk(irq_pend, 96'h0000_0001_0000_00C0_0000_0000, "R12 gated pending");
        wr(16'h0000, 32'h0);
        chk(irq_pend, '0, "R12 group-1 off");
        rd(16'h0204, 32'h0000_00C3, "R7 pending kept");
        wr(16'h0000, 32'h0000_0002);
        wr(16'h0284, 32'h0000_0080);
        rd(16'h0284, 32'h0000_0043, "R7 clear pending");
        chk(irq_pend, 96'h0000_0001_0000_0040_0000_0000, "R12 after clear");
        // Priority (R9)
        wr(16'h0420, 32'hA1B2_C3D4);
        rd(16'h0420, 32'hA1B2_C3D4, "R9 priority store");
        wr(16'h045C, 32'h1122_3344);
        rd(16'h045C, 32'h1122_3344, "R9 last priority word");
        wr(16'h0400, 32'hFFFF_FFFF);
        rd(16'h0400, 32'h0, "R9 private priority");
        wr(16'h0460, 32'hFFFF_FFFF);
        rd(16'h0460, 32'h0, "R9 past count");
        // Configuration (R10)
        wr(16'h0C08, 32'hAAAA_5555);
        rd(16'h0C08, 32'hAAAA_5555, "R10 config store");
        wr(16'h0C14, 32'h1234_5678);
        rd(16'h0C14, 32'h1234_5678, "R10 last config word");
        wr(16'h0C04, 32'hFFFF_FFFF);
        rd(16'h0C04, 32'h0, "R10 private config");
        wr(16'h0C18, 32'hFFFF_FFFF);
        rd(16'h0C18, 32'h0, "R10 past count");
        // Read-as-zero windows (R11)
        wr(16'h0304, 32'hFFFF_FFFF);
        rd(16'h0304, 32'h0, "R11 active");
        wr(16'h0804, 32'hFFFF_FFFF);
        rd(16'h0804, 32'h0, "R11 target");
        wr(16'h0040, 32'hFFFF_FFFF);
        rd(16'h0040, 32'h0, "R11 message");
        rd(16'h0D00, 32'h0, "R11 group modifier");
        rd(16'h2000, 32'h0, "R11 unmapped");
        chk(irq_pend, 96'h0000_0001_0000_0040_0000_0000, "R11 no side effect");
        rd(16'h0104, 32'h0000_00C0, "R11 enable untouched");
        // Idle read data (R13)
        @(negedge clk);
        n_chk++;
        if (bus_rdata !== 32'h0) begin
            n_fail++;
            $display("FAIL R13 idle read actual=%h expected=%h", bus_rdata, 32'h0);
        end
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule